// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the integer multiply/divide engine of a 32-bit in-order core. It owns the 64-bit HI:LO result pair. It takes a function code, a group select and two register operands through a valid/ready request port. Requests from the primary group cover signed and unsigned multiply, signed and unsigned divide, and moves between a general register and HI or LO. Requests from the secondary group cover multiply-accumulate and multiply-subtract into HI:LO, plus a three-operand multiply that returns only the low product word to the register file.

Multiplies, accumulates and moves finish at the clock edge that accepts them. Division is iterative: one restoring radix-2 step per cycle for 32 cycles. During that time `busy` is high and the request port refuses every request, so a pending read of HI or LO waits until the divide has written its result. Results headed for a general register return on `rd_valid`/`rd_data` one cycle after acceptance.

Top module: `hilo_unit`

## Requirements
- R1: During and immediately after synchronous reset, HI and LO read zero, and `busy` and `rd_valid` are low.
- R2: With `req_grp`=0, function 0x18 (signed) or 0x19 (unsigned) writes the upper half of the 64-bit product to HI and the lower half to LO at the accepting edge.
- R3: With `req_grp`=0, function 0x1A (signed) or 0x1B (unsigned) with a nonzero divisor places the quotient in LO and the remainder in HI. The signed quotient truncates toward zero and the signed remainder carries the dividend's sign. The most negative dividend divided by -1 gives quotient 0x80000000 and remainder 0.
- R4: A divide whose divisor is zero leaves HI and LO unchanged, never raises `busy`, and the port is ready again on the next cycle.
- R5: With `req_grp`=0, function 0x11 copies `req_a` into HI and 0x13 copies it into LO, visible after the accepting edge.
- R6: With `req_grp`=0, function 0x10 (HI) or 0x12 (LO) returns the register value held at acceptance on `rd_data`, with `rd_valid` high for exactly the next cycle.
- R7: With `req_grp`=1, function 0 adds the signed product to HI:LO and function 1 adds the unsigned product. Function 4 subtracts the signed product and function 5 subtracts the unsigned product. All four wrap modulo 2^64.
- R8: With `req_grp`=1, function 2 returns the low 32 bits of the signed product on `rd_data`, with `rd_valid` the next cycle, and leaves HI:LO unchanged.
- R9: While `busy` is high, `req_ready` is low and a held request is not accepted. A read of HI or LO held across a divide is accepted after `busy` falls and returns the divide's result.
- R10: A function code not listed above is accepted, changes neither HI nor LO, and produces no `rd_valid`.
- R11: A divide with a nonzero divisor holds `busy` high for exactly 32 cycles after the accepting edge. HI and LO change at the edge where `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_grp | input | 1 | Function group: 0 primary, 1 secondary |
| req_func | input | 6 | Function code within the group |
| req_a | input | 32 | First operand (dividend, multiplicand, move source) |
| req_b | input | 32 | Second operand (divisor, multiplier) |
| busy | output | 1 | Divide in progress |
| rd_valid | output | 1 | `rd_data` holds a register-file result |
| rd_data | output | 32 | Moved HI/LO value or low product word |
| hi_o | output | 32 | Current HI register |
| lo_o | output | 32 | Current LO register |

## Verification
The collision of interest is the end of a divide meeting a waiting read of HI or LO. The unit must not release the read in the cycle before the quotient and remainder land. The bench issues a divide and then holds a move-from request valid throughout the busy window. A reference model advances one cycle per clock and accepts that request only after its own 32-cycle count expires. The model therefore expects the divide's remainder or quotient on `rd_data`, and any early acceptance or stale value shows up as a mismatch on that cycle. The same model is also driven by a long pseudo-random mix of every function, which places moves, accumulates and zero-divisor divides directly behind divides.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_MFHI,
        OP_MTHI,
        OP_MFLO,
        OP_MTLO,
        OP_MULT,
        OP_MULTU,
        OP_DIV,
        OP_DIVU,
        OP_MADD,
        OP_MADDU,
        OP_MSUB,
        OP_MSUBU,
        OP_MUL3
    } hilo_op_e;

    typedef struct packed {
        hilo_op_e op;
        logic     is_div;
        logic     is_sgn;
        logic     to_gpr;
    } hilo_dec_t;

    function automatic hilo_op_e map_func(input logic grp, input logic [5:0] func);
        hilo_op_e r;
        r = OP_NONE;
        if (!grp) begin
            case (func)
                6'h10: r = OP_MFHI;
                6'h11: r = OP_MTHI;
                6'h12: r = OP_MFLO;
                6'h13: r = OP_MTLO;
                6'h18: r = OP_MULT;
                6'h19: r = OP_MULTU;
                6'h1A: r = OP_DIV;
                6'h1B: r = OP_DIVU;
                default: r = OP_NONE;
            endcase
        end else begin
            case (func)
                6'h00: r = OP_MADD;
                6'h01: r = OP_MADDU;
                6'h02: r = OP_MUL3;
                6'h04: r = OP_MSUB;
                6'h05: r = OP_MSUBU;
                default: r = OP_NONE;
            endcase
        end
        return r;
    endfunction

    function automatic logic op_signed(input hilo_op_e op);
        return (op == OP_MULT) || (op == OP_DIV) || (op == OP_MADD) ||
               (op == OP_MSUB) || (op == OP_MUL3);
    endfunction

endpackage

// File: rtl/hilo_decode.sv
module hilo_decode
    import hilo_pkg::*;
(
    input  logic       grp,
    input  logic [5:0] func,
    output hilo_dec_t  dec
);
    always_comb begin
        dec.op     = map_func(grp, func);
        dec.is_div = (dec.op == OP_DIV) || (dec.op == OP_DIVU);
        dec.is_sgn = op_signed(dec.op);
        dec.to_gpr = (dec.op == OP_MFHI) || (dec.op == OP_MFLO) || (dec.op == OP_MUL3);
    end
endmodule

// File: rtl/hilo_mac.sv
module hilo_mac
    import hilo_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  hilo_op_e              op,
    input  logic                  sgn,
    input  logic [XLEN-1:0]       a,
    input  logic [XLEN-1:0]       b,
    input  logic [2*XLEN-1:0]     acc,
    output logic [2*XLEN-1:0]     acc_next,
    output logic [XLEN-1:0]       prod_low
);
    localparam int PW = 2 * XLEN;

    logic [PW-1:0] ext_a;
    logic [PW-1:0] ext_b;
    logic [PW-1:0] prod;

    // one shared multiplier: operands extended by the signedness flag
    assign ext_a = {{XLEN{sgn & a[XLEN-1]}}, a};
    assign ext_b = {{XLEN{sgn & b[XLEN-1]}}, b};
    assign prod  = ext_a * ext_b;
    assign prod_low = prod[XLEN-1:0];

    always_comb begin
        case (op)
            OP_MULT, OP_MULTU: acc_next = prod;
            OP_MADD, OP_MADDU: acc_next = acc + prod;
            OP_MSUB, OP_MSUBU: acc_next = acc - prod;
            default:           acc_next = acc;
        endcase
    end
endmodule

// File: rtl/hilo_div.sv
module hilo_div #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            sgn,
    input  logic [XLEN-1:0] dividend,
    input  logic [XLEN-1:0] divisor,
    output logic            active_o,
    output logic            done_o,
    output logic [XLEN-1:0] quo_o,
    output logic [XLEN-1:0] rem_o
);
    localparam int CW = $clog2(XLEN);
    localparam logic [CW-1:0] LAST = CW'(XLEN - 1);

    logic            active;
    logic [CW-1:0]   cnt;
    logic [XLEN-1:0] quo;
    logic [XLEN-1:0] rem;
    logic [XLEN-1:0] dvs;
    logic            neg_q;
    logic            neg_r;

    logic [XLEN:0]   shifted;
    logic [XLEN:0]   diff;
    logic            take;
    logic [XLEN-1:0] rem_n;
    logic [XLEN-1:0] quo_n;

    logic            a_neg;
    logic            b_neg;

    assign a_neg = sgn & dividend[XLEN-1];
    assign b_neg = sgn & divisor[XLEN-1];

    // one restoring step per cycle
    assign shifted = {rem, quo[XLEN-1]};
    assign diff    = shifted - {1'b0, dvs};
    assign take    = ~diff[XLEN];
    assign rem_n   = take ? diff[XLEN-1:0] : shifted[XLEN-1:0];
    assign quo_n   = {quo[XLEN-2:0], take};

    assign active_o = active;
    assign done_o   = active && (cnt == LAST);
    assign quo_o    = neg_q ? (~quo_n + 1'b1) : quo_n;
    assign rem_o    = neg_r ? (~rem_n + 1'b1) : rem_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            quo    <= '0;
            rem    <= '0;
            dvs    <= '0;
            neg_q  <= 1'b0;
            neg_r  <= 1'b0;
        end else if (start && !active) begin
            active <= 1'b1;
            cnt    <= '0;
            quo    <= a_neg ? (~dividend + 1'b1) : dividend;
            dvs    <= b_neg ? (~divisor + 1'b1) : divisor;
            rem    <= '0;
            neg_q  <= a_neg ^ b_neg;
            neg_r  <= a_neg;
        end else if (active) begin
            quo <= quo_n;
            rem <= rem_n;
            cnt <= cnt + 1'b1;
            if (cnt == LAST) active <= 1'b0;
        end
    end

    // R11
    div_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> ($past(cnt) == LAST));

    // R11
    div_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> (cnt == '0));

endmodule

// File: rtl/hilo_unit.sv
module hilo_unit
    import hilo_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_grp,
    input  logic [5:0]      req_func,
    input  logic [XLEN-1:0] req_a,
    input  logic [XLEN-1:0] req_b,
    output logic            busy,
    output logic            rd_valid,
    output logic [XLEN-1:0] rd_data,
    output logic [XLEN-1:0] hi_o,
    output logic [XLEN-1:0] lo_o
);
    localparam int PW = 2 * XLEN;

    hilo_dec_t       dec;
    logic            acc_en;
    logic [XLEN-1:0] hi_q;
    logic [XLEN-1:0] lo_q;
    logic [PW-1:0]   mac_next;
    logic [XLEN-1:0] mac_low;
    logic            div_start;
    logic            div_active;
    logic            div_done;
    logic [XLEN-1:0] div_quo;
    logic [XLEN-1:0] div_rem;

    hilo_decode u_dec (
        .grp  (req_grp),
        .func (req_func),
        .dec  (dec)
    );

    hilo_mac #(.XLEN(XLEN)) u_mac (
        .op       (dec.op),
        .sgn      (dec.is_sgn),
        .a        (req_a),
        .b        (req_b),
        .acc      ({hi_q, lo_q}),
        .acc_next (mac_next),
        .prod_low (mac_low)
    );

    assign div_start = acc_en && dec.is_div && (req_b != '0);

    hilo_div #(.XLEN(XLEN)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .sgn      (dec.is_sgn),
        .dividend (req_a),
        .divisor  (req_b),
        .active_o (div_active),
        .done_o   (div_done),
        .quo_o    (div_quo),
        .rem_o    (div_rem)
    );

    assign busy      = div_active;
    assign req_ready = ~div_active;
    assign acc_en    = req_valid && req_ready;
    assign hi_o      = hi_q;
    assign lo_o      = lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q     <= '0;
            lo_q     <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (div_done) begin
                hi_q <= div_rem;
                lo_q <= div_quo;
            end else if (acc_en) begin
                case (dec.op)
                    OP_MTHI: hi_q <= req_a;
                    OP_MTLO: lo_q <= req_a;
                    OP_MFHI: begin
                        rd_valid <= 1'b1;
                        rd_data  <= hi_q;
                    end
                    OP_MFLO: begin
                        rd_valid <= 1'b1;
                        rd_data  <= lo_q;
                    end
                    OP_MUL3: begin
                        rd_valid <= 1'b1;
                        rd_data  <= mac_low;
                    end
                    OP_MULT, OP_MULTU, OP_MADD, OP_MADDU, OP_MSUB, OP_MSUBU:
                        {hi_q, lo_q} <= mac_next;
                    default: ;
                endcase
            end
        end
    end

    // R4
    zero_div_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && dec.is_div && req_b == '0)
        |=> (!busy && $stable(hi_q) && $stable(lo_q)));

    // R6
    move_from_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && dec.op == OP_MFHI)
        |=> (rd_valid && rd_data == $past(hi_q)));

    // R8
    mul3_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && dec.op == OP_MUL3)
        |=> (rd_valid && $stable(hi_q) && $stable(lo_q)));

    // R10
    unknown_func_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && dec.op == OP_NONE)
        |=> (!rd_valid && $stable(hi_q) && $stable(lo_q)));

    // R9
    no_result_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !$past(busy));

endmodule

// File: tb/hilo_unit_bench.sv
module hilo_unit_bench;

    logic        clk;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic        req_grp;
    logic [5:0]  req_func;
    logic [31:0] req_a;
    logic [31:0] req_b;
    logic        busy;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [31:0] hi_o;
    logic [31:0] lo_o;

    hilo_unit u_hilo_unit (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_grp   (req_grp),
        .req_func  (req_func),
        .req_a     (req_a),
        .req_b     (req_b),
        .busy      (busy),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .hi_o      (hi_o),
        .lo_o      (lo_o)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit started = 0;
    bit finished = 0;

    // reference model state
    logic [31:0] m_hi, m_lo, p_hi, p_lo, m_rdd;
    bit          m_rdv;
    int          m_left;
    string       m_tag;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic model_apply();
        logic [63:0] acc, sp, up;
        longint sa, sb;
        acc = {m_hi, m_lo};
        sa  = longint'($signed(req_a));
        sb  = longint'($signed(req_b));
        sp  = 64'(sa * sb);
        up  = {32'b0, req_a} * {32'b0, req_b};
        case ({req_grp, req_func})
            7'h10: begin m_rdv = 1; m_rdd = m_hi; m_tag = "R6"; end
            7'h11: begin m_hi = req_a; m_tag = "R5"; end
            7'h12: begin m_rdv = 1; m_rdd = m_lo; m_tag = "R6"; end
            7'h13: begin m_lo = req_a; m_tag = "R5"; end
            7'h18: begin {m_hi, m_lo} = sp; m_tag = "R2"; end
            7'h19: begin {m_hi, m_lo} = up; m_tag = "R2"; end
            7'h1A, 7'h1B: begin
                if (req_b == 0) m_tag = "R4";
                else begin
                    m_tag = "R3";
                    m_left = 32;
                    if (req_func == 6'h1A) begin
                        p_lo = 32'(sa / sb);
                        p_hi = 32'(sa % sb);
                    end else begin
                        p_lo = req_a / req_b;
                        p_hi = req_a % req_b;
                    end
                end
            end
            7'h40: begin {m_hi, m_lo} = acc + sp; m_tag = "R7"; end
            7'h41: begin {m_hi, m_lo} = acc + up; m_tag = "R7"; end
            7'h44: begin {m_hi, m_lo} = acc - sp; m_tag = "R7"; end
            7'h45: begin {m_hi, m_lo} = acc - up; m_tag = "R7"; end
            7'h42: begin m_rdv = 1; m_rdd = sp[31:0]; m_tag = "R8"; end
            default: m_tag = "R10";
        endcase
    endtask

    always @(posedge clk) begin
        started = 1;
        cycles++;
        if (rst) begin
            m_hi = 0; m_lo = 0; m_left = 0; m_rdv = 0; m_rdd = 0; m_tag = "R1";
        end else begin
            m_rdv = 0;
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) begin
                    m_hi = p_hi; m_lo = p_lo;
                end
            end else if (req_valid) begin
                model_apply();
            end
        end
        if (cycles > 150000 && !finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog run did not finish actual=%0d expected=<150000", cycles);
            report();
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started && !finished) begin
            chk("R11", "busy", 64'(busy), 64'(m_left > 0));
            chk("R9", "req_ready", 64'(req_ready), 64'(m_left == 0));
            chk(m_tag, "hi", 64'(hi_o), 64'(m_hi));
            chk(m_tag, "lo", 64'(lo_o), 64'(m_lo));
            chk(m_tag, "rd_valid", 64'(rd_valid), 64'(m_rdv));
            if (m_rdv) chk(m_tag, "rd_data", 64'(rd_data), 64'(m_rdd));
        end
    end

    // hold a request until the port takes it
    task automatic send(input logic grp, input logic [5:0] func,
                        input logic [31:0] a, input logic [31:0] b);
        bit took;
        @(negedge clk);
        req_grp = grp; req_func = func; req_a = a; req_b = b; req_valid = 1'b1;
        forever begin
            took = req_ready;
            @(negedge clk);
            if (took) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] xs(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    logic [31:0] seed;
    logic [6:0]  codes [14];

    initial begin
        req_valid = 0; req_grp = 0; req_func = 0; req_a = 0; req_b = 0;
        rst = 1;
        idle(4);
        // R1 reset state checked per cycle with tag R1
        rst = 0;
        idle(2);

        // R5 / R6 moves
        send(0, 6'h11, 32'h12345678, 0);
        send(0, 6'h13, 32'h9abcdef0, 0);
        send(0, 6'h10, 0, 0);
        send(0, 6'h12, 0, 0);
        // R2 multiplies
        send(0, 6'h18, 32'hFFFFFFFD, 32'd7);
        send(0, 6'h19, 32'hFFFFFFFF, 32'hFFFFFFFF);
        send(0, 6'h18, 32'h80000000, 32'h80000000);
        // R7 accumulate forms
        send(1, 6'h00, 32'hFFFFFFFF, 32'd2);
        send(1, 6'h01, 32'hFFFFFFFF, 32'd2);
        send(1, 6'h04, 32'd5, 32'hFFFFFFF0);
        send(1, 6'h05, 32'h10000, 32'h10000);
        // R8 low product word
        send(1, 6'h02, 32'hFFFF0001, 32'hFFFFFFFE);
        // R3 / R11 divides, every sign combination
        send(0, 6'h1A, 32'd100, 32'd7);
        send(0, 6'h1A, 32'hFFFFFF9C, 32'd7);
        send(0, 6'h1A, 32'd100, 32'hFFFFFFF9);
        send(0, 6'h1A, 32'hFFFFFF9C, 32'hFFFFFFF9);
        send(0, 6'h1B, 32'hFFFFFFFF, 32'd3);
        send(0, 6'h1A, 32'h80000000, 32'hFFFFFFFF);
        send(0, 6'h1B, 32'd5, 32'd9);
        // R4 zero divisor
        send(0, 6'h11, 32'hAAAA5555, 0);
        send(0, 6'h1A, 32'd77, 32'd0);
        send(0, 6'h1B, 32'd77, 32'd0);
        send(0, 6'h10, 0, 0);
        // R9 read held through a divide
        send(0, 6'h1B, 32'd1000, 32'd33);
        send(0, 6'h10, 0, 0);
        send(0, 6'h12, 0, 0);
        send(0, 6'h1A, 32'hFFFFF000, 32'd10);
        send(1, 6'h02, 32'd3, 32'd4);
        // R10 unassigned codes
        send(0, 6'h14, 32'h1, 32'h2);
        send(1, 6'h03, 32'h5, 32'h6);
        send(0, 6'h00, 32'h7, 32'h8);
        send(1, 6'h1A, 32'h9, 32'h3);
        idle(2);

        // pseudo-random mix
        codes = '{7'h10, 7'h11, 7'h12, 7'h13, 7'h18, 7'h19, 7'h1A,
                  7'h1B, 7'h40, 7'h41, 7'h42, 7'h44, 7'h45, 7'h17};
        seed = 32'h1234ABCD;
        for (int k = 0; k < 400; k++) begin
            logic [6:0]  c;
            logic [31:0] a, b;
            seed = xs(seed); c = codes[seed % 14];
            seed = xs(seed); a = seed;
            seed = xs(seed); b = (seed[3:0] == 0) ? 32'd0 : (seed[4] ? (seed >> seed[9:5]) : seed);
            send(c[6], c[5:0], a, b);
        end
        idle(40);
        finished = 1;
        report();
    end

endmodule